// File: doc/BRIEF.md
# Presampling Voltage Selector

Before each conversion chain, an ADC front end can precharge its sampling capacitor from one of four internally generated reference voltages. This block drives the four analog switch enables, exactly one at a time, that pick that voltage.

There are two ways the voltage is chosen:

- **Static mode.** Each of three channel groups has its own 2-bit selection code. The group is taken from the upper bits of the channel number now being converted.
- **Counter mode.** A rotation counter replaces every static code. It starts at the first voltage when a conversion starts. It steps by one voltage each time a chain completes, or each time a scan chain wraps around.

All inputs are plain control pins. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure. Strobes are single-cycle pulses, sampled on the rising clock edge. Reset is synchronous and active low. The enable output is formed from the registered state and the current codes, channel number and mode bit.

Top module: `presample_sel`

## Requirements
- R1: A 2-bit selection value drives the enable one-hot. Value 0 gives `sw_en`=0001, 1 gives 0010, 2 gives 0100 and 3 gives 1000. No more than one enable bit is ever high.
- R2: In static mode, channels 0 to 31 use `grp0_code`.
- R3: In static mode, channels 32 to 63 use `grp1_code`.
- R4: In static mode, channels 64 to 127 use `grp2_code`.
- R5: While `cnt_mode` is 1, the rotation counter sets the enable and all three group codes are ignored.
- R6: A `conv_start` pulse makes the block active from the next cycle, with the counter at 0. In counter mode, the first chain therefore sees 0001.
- R7: In counter mode, a `chain_done` pulse while active advances the counter by one, visible the next cycle.
- R8: In counter mode, a `scan_wrap` pulse while active advances the counter by one. When `chain_done` and `scan_wrap` arrive in the same cycle, the counter advances by one only.
- R9: The counter wraps from 3 back to 0 (1000 is followed by 0001).
- R10: `sw_en` is 0000 after reset, and while no conversion is active. A `conv_stop` pulse makes the block inactive from the next cycle.
- R11: A `conv_start` during an active rotation returns the counter to 0. `conv_start` wins over any advance pulse in the same cycle.
- R12: Advance pulses while `cnt_mode` is 0 leave the counter unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| grp0_code | input | 2 | Static selection code for channels 0–31 |
| grp1_code | input | 2 | Static selection code for channels 32–63 |
| grp2_code | input | 2 | Static selection code for channels 64 and above |
| cnt_mode | input | 1 | 1 = rotation counter overrides the static codes |
| chan_num | input | 7 | Channel number now being converted |
| conv_start | input | 1 | Conversion start pulse |
| chain_done | input | 1 | Conversion chain complete pulse |
| scan_wrap | input | 1 | Scan chain wrap-around pulse |
| conv_stop | input | 1 | Conversion end pulse |
| sw_en | output | 4 | One-hot precharge switch enable |

## Verification
The static path is first checked with a different code in each group. The channel number then walks across every group edge (31/32, 63/64) and up to 127. A wrong group boundary or a swapped group code therefore shows up as the wrong enable bit.

The counter path is then driven with each advance source on its own, with both together, and through the wrap point. These cases separate a double step from a single step, and a missing wrap from a correct one. A restart in the middle of the rotation confirms that the counter returns to the first voltage.

Advance pulses are sent while counter mode is off, and the mode is then switched on. The enable must show the first voltage, which tells a held counter from one that moved in the background. Stop and reset cases confirm that the enable is all zeros whenever no conversion is active.

// File: rtl/presample_pkg.sv
package presample_pkg;
  localparam int unsigned PS_NUM_VOLT  = 4;
  localparam int unsigned PS_SEL_W     = $clog2(PS_NUM_VOLT);
  localparam int unsigned PS_NUM_GRP   = 3;
  localparam int unsigned PS_CHAN_W    = 7;
  localparam int unsigned PS_GRP_SHIFT = 5;
endpackage

// File: rtl/presample_grp_mux.sv
module presample_grp_mux
  import presample_pkg::*;
#(
  parameter int unsigned SEL_W     = PS_SEL_W,
  parameter int unsigned N_GRP     = PS_NUM_GRP,
  parameter int unsigned CH_W      = PS_CHAN_W,
  parameter int unsigned GRP_SHIFT = PS_GRP_SHIFT
) (
  input  logic [N_GRP*SEL_W-1:0] codes,
  input  logic [CH_W-1:0]        chan,
  output logic [SEL_W-1:0]       sel
);
  localparam int unsigned HI_W = CH_W - GRP_SHIFT;

  logic [HI_W-1:0] hi;
  assign hi = chan[CH_W-1:GRP_SHIFT];

  // Every group index past the last one folds onto the last code.
  always_comb begin
    sel = codes[(N_GRP-1)*SEL_W +: SEL_W];
    for (int g = N_GRP - 2; g >= 0; g--) begin
      if (hi == HI_W'(g)) sel = codes[g*SEL_W +: SEL_W];
    end
  end
endmodule

// File: rtl/presample_rot.sv
module presample_rot
  import presample_pkg::*;
#(
  parameter int unsigned N_VOLT = PS_NUM_VOLT,
  parameter int unsigned SEL_W  = PS_SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic             adv,
  input  logic             cnt_mode,
  output logic             act,
  output logic [SEL_W-1:0] cnt
);
  localparam logic [SEL_W-1:0] LAST = SEL_W'(N_VOLT - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act <= 1'b0;
      cnt <= '0;
    end else if (start) begin
      act <= 1'b1;
      cnt <= '0;
    end else begin
      if (stop) act <= 1'b0;
      if (act && cnt_mode && adv) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/presample_onehot.sv
module presample_onehot
  import presample_pkg::*;
#(
  parameter int unsigned N_VOLT = PS_NUM_VOLT,
  parameter int unsigned SEL_W  = PS_SEL_W
) (
  input  logic              en,
  input  logic [SEL_W-1:0]  sel,
  output logic [N_VOLT-1:0] oh
);
  for (genvar v = 0; v < N_VOLT; v++) begin : g_bit
    assign oh[v] = en && (sel == SEL_W'(v));
  end
endmodule

// File: rtl/presample_sel.sv
module presample_sel
  import presample_pkg::*;
#(
  parameter int unsigned N_VOLT    = PS_NUM_VOLT,
  parameter int unsigned SEL_W     = PS_SEL_W,
  parameter int unsigned CH_W      = PS_CHAN_W,
  parameter int unsigned GRP_SHIFT = PS_GRP_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  grp0_code,
  input  logic [SEL_W-1:0]  grp1_code,
  input  logic [SEL_W-1:0]  grp2_code,
  input  logic              cnt_mode,
  input  logic [CH_W-1:0]   chan_num,
  input  logic              conv_start,
  input  logic              chain_done,
  input  logic              scan_wrap,
  input  logic              conv_stop,
  output logic [N_VOLT-1:0] sw_en
);
  localparam int unsigned N_GRP = 3;

  logic [SEL_W-1:0] grp_sel;
  logic [SEL_W-1:0] rot_q;
  logic [SEL_W-1:0] fin_sel;
  logic             act_q;

  presample_grp_mux #(
    .SEL_W(SEL_W), .N_GRP(N_GRP), .CH_W(CH_W), .GRP_SHIFT(GRP_SHIFT)
  ) u_grp (
    .codes({grp2_code, grp1_code, grp0_code}),
    .chan (chan_num),
    .sel  (grp_sel)
  );

  presample_rot #(.N_VOLT(N_VOLT), .SEL_W(SEL_W)) u_rot (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (conv_start),
    .stop    (conv_stop),
    .adv     (chain_done | scan_wrap),
    .cnt_mode(cnt_mode),
    .act     (act_q),
    .cnt     (rot_q)
  );

  // Counter mode takes priority over the static group codes.
  assign fin_sel = cnt_mode ? rot_q : grp_sel;

  presample_onehot #(.N_VOLT(N_VOLT), .SEL_W(SEL_W)) u_oh (
    .en (act_q),
    .sel(fin_sel),
    .oh (sw_en)
  );
endmodule

// File: rtl/presample_sel_chk.sv
module presample_sel_chk #(
  parameter int unsigned N_VOLT = 4,
  parameter int unsigned SEL_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              conv_start,
  input logic              chain_done,
  input logic              scan_wrap,
  input logic              cnt_mode,
  input logic              act,
  input logic [SEL_W-1:0]  cnt,
  input logic [N_VOLT-1:0] sw_en
);
  localparam logic [SEL_W-1:0] LAST = SEL_W'(N_VOLT - 1);

  assert_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sw_en));

  assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !act |-> sw_en == '0);

  assert_override_R5: assert property (@(posedge clk) disable iff (!rst_n)
    act && cnt_mode |-> sw_en == (N_VOLT'(1) << cnt));

  assert_start_zero_R6_R11: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> act && cnt == '0);

  assert_step_R7_R8_R9: assert property (@(posedge clk) disable iff (!rst_n)
    act && cnt_mode && (chain_done || scan_wrap) && !conv_start |=>
      cnt == (($past(cnt) == LAST) ? '0 : $past(cnt) + 1'b1));

  assert_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_mode && !conv_start |=> $stable(cnt));
endmodule

bind presample_sel presample_sel_chk #(.N_VOLT(N_VOLT), .SEL_W(SEL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .conv_start(conv_start),
  .chain_done(chain_done),
  .scan_wrap (scan_wrap),
  .cnt_mode  (cnt_mode),
  .act       (act_q),
  .cnt       (rot_q),
  .sw_en     (sw_en)
);

// File: tb/tb_presample_sel.sv
module tb_presample_sel;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] grp0_code = 2'd0, grp1_code = 2'd0, grp2_code = 2'd0;
  logic       cnt_mode = 1'b0;
  logic [6:0] chan_num = '0;
  logic       conv_start = 1'b0, chain_done = 1'b0, scan_wrap = 1'b0, conv_stop = 1'b0;
  logic [3:0] sw_en;

  always #4 clk = ~clk;

  presample_sel dut (
    .clk(clk), .rst_n(rst_n), .grp0_code(grp0_code), .grp1_code(grp1_code),
    .grp2_code(grp2_code), .cnt_mode(cnt_mode), .chan_num(chan_num),
    .conv_start(conv_start), .chain_done(chain_done), .scan_wrap(scan_wrap),
    .conv_stop(conv_stop), .sw_en(sw_en)
  );

  typedef struct { logic [3:0] exp; string tag; } item_t;
  item_t sbq[$];
  int n_chk = 0, n_fail = 0;
  bit m_act = 0;
  int m_cnt = 0;
  bit done_flag = 0;

  task automatic chk(logic [3:0] got, logic [3:0] exp, string tag);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: sw_en=%b expected %b", tag, got, exp);
    end
  endtask

  function automatic logic [3:0] model_out();
    int s;
    if (!m_act) return 4'b0000;
    if (cnt_mode) s = m_cnt;
    else if (chan_num < 32) s = grp0_code;
    else if (chan_num < 64) s = grp1_code;
    else s = grp2_code;
    return 4'b0001 << s;
  endfunction

  // Driver: strobes for one edge, model update, expected item pushed.
  task automatic step(bit st, bit dn, bit wr, bit sp, string tag);
    item_t it;
    @(negedge clk);
    conv_start = st; chain_done = dn; scan_wrap = wr; conv_stop = sp;
    if (st) begin
      m_act = 1; m_cnt = 0;
    end else begin
      if (m_act && cnt_mode && (dn || wr)) m_cnt = (m_cnt + 1) % 4;
      if (sp) m_act = 0;
    end
    it.exp = model_out();
    it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic cfg(bit cm, logic [6:0] ch, logic [1:0] c0, logic [1:0] c1, logic [1:0] c2);
    @(negedge clk);
    conv_start = 0; chain_done = 0; scan_wrap = 0; conv_stop = 0;
    cnt_mode = cm; chan_num = ch; grp0_code = c0; grp1_code = c1; grp2_code = c2;
  endtask

  // Monitor: samples 3 ns after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #3;
      if (sbq.size() > 0) begin
        item_t it;
        it = sbq.pop_front();
        chk(sw_en, it.exp, it.tag);
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!done_flag) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(sw_en, 4'b0000, "R10 reset state");
    rst_n = 1'b1;

    // Static mode: a distinct code in each group.
    cfg(0, 7'd5, 2'd2, 2'd1, 2'd3);
    step(1, 0, 0, 0, "R6 start static, R2 chan 5");
    cfg(0, 7'd31, 2'd2, 2'd1, 2'd3);  step(0, 0, 0, 0, "R2 chan 31");
    cfg(0, 7'd32, 2'd2, 2'd1, 2'd3);  step(0, 0, 0, 0, "R3 chan 32");
    cfg(0, 7'd63, 2'd2, 2'd1, 2'd3);  step(0, 0, 0, 0, "R3 chan 63");
    cfg(0, 7'd64, 2'd2, 2'd1, 2'd3);  step(0, 0, 0, 0, "R4 chan 64");
    cfg(0, 7'd127, 2'd2, 2'd1, 2'd3); step(0, 0, 0, 0, "R4 chan 127");
    for (int c = 0; c < 4; c++) begin
      cfg(0, 7'd0, 2'(c), 2'd1, 2'd3);
      step(0, 0, 0, 0, "R1 code map");
    end

    // Advance pulses with counter mode off, then switch it on.
    cfg(0, 7'd40, 2'd2, 2'd1, 2'd3);
    step(0, 1, 0, 0, "R12 done ignored");
    step(0, 0, 1, 0, "R12 wrap ignored");
    step(0, 1, 1, 0, "R12 both ignored");
    cfg(1, 7'd40, 2'd2, 2'd1, 2'd3);
    step(0, 0, 0, 0, "R12 R5 counter held at V0");

    // Counter mode rotation.
    step(0, 1, 0, 0, "R7 chain done step");
    step(0, 0, 1, 0, "R8 scan wrap step");
    step(0, 1, 1, 0, "R8 both pulses single step");
    step(0, 1, 0, 0, "R9 wrap to V0");
    cfg(1, 7'd100, 2'd3, 2'd3, 2'd3);
    step(0, 0, 0, 0, "R5 codes ignored");
    step(0, 1, 0, 0, "R7 step again");
    step(0, 0, 1, 0, "R8 step again");
    step(1, 1, 0, 0, "R11 restart beats advance");
    step(0, 0, 1, 0, "R8 after restart");

    // Stop and inactive behaviour.
    step(0, 0, 0, 1, "R10 stop clears");
    cfg(0, 7'd70, 2'd1, 2'd1, 2'd2);
    step(0, 0, 0, 0, "R10 inactive static");
    step(0, 1, 1, 0, "R10 pulses while inactive");
    cfg(1, 7'd70, 2'd1, 2'd1, 2'd2);
    step(1, 0, 0, 0, "R6 counter start at V0");
    step(0, 1, 0, 1, "R10 stop with advance");

    repeat (3) @(posedge clk);
    #4;
    done_flag = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule